// File: doc/BRIEF.md
# Cipher Unit Error and Interrupt Controller

This block guards the host register window of a block-cipher execution unit and turns faults into one interrupt. It watches every register read and write on a simple synchronous bus and compares them against the busy flag from the cipher core. It also checks configuration values as they are written. Each fault it finds sets a sticky bit in a 64-bit status word. A companion mask word can disable each fault class, and the interrupt line is high whenever any status bit is set.

Fault bit positions use a numbering where bit 0 is the MSB of the 64-bit word. Integrity mismatch is bit 49, core fault is 51, early context read is 52, busy-write violation is 53, bad key length is 54, bad data length is 55 and bad mode is 56. In the LSB-0 indexing of the RTL these are bits 14, 12, 11, 10, 9, 8 and 7. All other bits of both words are reserved.

The local map uses word addresses. Address 0 is mode, 1 is key length, 2 is data length, 4–5 are the IV words, 8–11 are the key words, 16 is status and 17 is mask. The IV and key words are the context registers. Reads of any address other than status and mask return zero.

Top module: `cu_err_irq`

## Requirements
- R1: After reset the mask word reads 0x0000_0000_0000_5F80 (every fault disabled), the status word reads 0 and `irq` is 0.
- R2: While a mask bit is 1 the matching status bit reads 0. A fault arriving in that class is dropped. Setting a mask bit clears a status bit that was already set.
- R3: A write to the key-length register (address 1) with a value other than 16, 24 or 32 sets the bad-key-length bit (LSB index 9), unless that bit is masked. Writes of 16, 24 or 32 set nothing.
- R4: A read of an IV or key address (4–5, 8–11) while `busy` is 1 sets the early-read bit (LSB index 11). Reads of status or mask while busy set nothing.
- R5: A write to mode, key length, data length, IV or key while `busy` is 1 sets the busy-write bit (LSB index 10). The same write while idle sets nothing.
- R6: A write to the mode register with any bit set outside the legal field (the low 8 bits with default parameters) sets the bad-mode bit (LSB index 7).
- R7: A write to the data-length register while `size_ok` is 0 sets the bad-data-length bit (LSB index 8). A pulse on `icv_bad` sets bit 14. A pulse on `core_fault` sets bit 12.
- R8: Status bits are sticky. A bit clears only when 1 is written to it at address 16. If a new fault and the clear of that bit occur in the same cycle, the bit stays set.
- R9: `irq` is the OR of all status bits. It goes high in the cycle after the edge that samples the fault.
- R10: Reserved bits of status and mask read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Word address of the access |
| we | input | 1 | Write strobe |
| wdata | input | 64 | Write data |
| re | input | 1 | Read strobe |
| rdata | output | 64 | Read data (combinational) |
| busy | input | 1 | Cipher core is processing |
| size_ok | input | 1 | Core verdict on the data length being written this cycle |
| icv_bad | input | 1 | Pulse: computed check value mismatched |
| core_fault | input | 1 | Pulse: internal processing error |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `we` and `re` are never high in the same cycle. They also assume that `size_ok` is meaningful only in a cycle that writes the data-length register. The fault-setting properties check only the cycle after an access, and they assume the mask is not being rewritten in that same cycle. This holds because a mask write targets a different address from the access being checked. The bench uses one strobe per cycle and changes `busy` and the pulse inputs only at falling edges, between accesses. It clears all status bits at the start of each scenario, so every expected value is a single known bit.

// File: rtl/cu_err_irq.sv
module cu_err_irq #(
  parameter int          AW        = 6,
  parameter logic [63:0] MODE_RSVD = 64'hFFFF_FFFF_FFFF_FF00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [63:0]   wdata,
  input  logic          re,
  output logic [63:0]   rdata,
  input  logic          busy,
  input  logic          size_ok,
  input  logic          icv_bad,
  input  logic          core_fault,
  output logic          irq
);
  localparam logic [AW-1:0] A_MODE = AW'(0),  A_KLEN = AW'(1),  A_DLEN = AW'(2);
  localparam logic [AW-1:0] A_IV0  = AW'(4),  A_IV1  = AW'(5);
  localparam logic [AW-1:0] A_KEY0 = AW'(8),  A_KEY3 = AW'(11);
  localparam logic [AW-1:0] A_STAT = AW'(16), A_MASK = AW'(17);

  localparam int B_MODE = 63 - 56, B_DLEN = 63 - 55, B_KLEN = 63 - 54;
  localparam int B_BUSYW = 63 - 53, B_EARLY = 63 - 52, B_CORE = 63 - 51;
  localparam int B_ICV = 63 - 49;
  localparam logic [63:0] FLD = (64'd1 << B_MODE) | (64'd1 << B_DLEN) |
    (64'd1 << B_KLEN) | (64'd1 << B_BUSYW) | (64'd1 << B_EARLY) |
    (64'd1 << B_CORE) | (64'd1 << B_ICV);

  logic [63:0] stat_q, mask_q, evt, clr, mask_nxt, stat_nxt;

  wire is_ctx = (addr == A_IV0) || (addr == A_IV1) ||
                (addr >= A_KEY0 && addr <= A_KEY3);
  wire is_cfg = is_ctx || addr == A_MODE || addr == A_KLEN || addr == A_DLEN;
  wire klen_ok = wdata == 64'd16 || wdata == 64'd24 || wdata == 64'd32;

  always_comb begin
    evt = '0;
    evt[B_MODE]  = we && addr == A_MODE && |(wdata & MODE_RSVD);
    evt[B_DLEN]  = we && addr == A_DLEN && !size_ok;
    evt[B_KLEN]  = we && addr == A_KLEN && !klen_ok;
    evt[B_BUSYW] = we && busy && is_cfg;
    evt[B_EARLY] = re && busy && is_ctx;
    evt[B_CORE]  = core_fault;
    evt[B_ICV]   = icv_bad;
  end

  assign mask_nxt = (we && addr == A_MASK) ? (wdata & FLD) : mask_q;
  assign clr      = (we && addr == A_STAT) ? (wdata & FLD) : '0;
  assign stat_nxt = ((stat_q & ~clr) | evt) & ~mask_nxt & FLD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= FLD;
    end else begin
      stat_q <= stat_nxt;
      mask_q <= mask_nxt;
    end
  end

  assign irq   = |stat_q;
  assign rdata = (addr == A_STAT) ? stat_q : (addr == A_MASK) ? mask_q : '0;

  assert_masked_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & mask_q) == 64'd0);
  assert_klen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we && addr == A_KLEN && !klen_ok && !mask_q[B_KLEN] |=> stat_q[B_KLEN]);
  assert_early_R4: assert property (@(posedge clk) disable iff (!rst_n)
    re && busy && is_ctx && !mask_q[B_EARLY] |=> stat_q[B_EARLY]);
  assert_busyw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we && busy && is_cfg && !mask_q[B_BUSYW] |=> stat_q[B_BUSYW]);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && (addr == A_STAT || addr == A_MASK)) |=>
      (stat_q & $past(stat_q)) == $past(stat_q));
  assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~mask_q) != 64'd0 && !(we && addr == A_MASK) |=> irq);
  assert_rsvd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q | mask_q) & ~FLD) == 64'd0);
endmodule

// File: tb/cu_err_irq_test.sv
`timescale 1ns/1ps
module cu_err_irq_test;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0;
  logic busy = 1'b0, size_ok = 1'b1, icv_bad = 1'b0, core_fault = 1'b0;
  logic [5:0] addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cu_err_irq uut (.clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
    .re(re), .rdata(rdata), .busy(busy), .size_ok(size_ok), .icv_bad(icv_bad),
    .core_fault(core_fault), .irq(irq));

  localparam logic [5:0] MODE = 0, KLEN = 1, DLEN = 2, IV0 = 4, KEY1 = 9, STAT = 16, MASK = 17;

  function automatic logic [63:0] fb(input int n);
    return 64'd1 << (63 - n);
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [63:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [63:0] d);
    @(negedge clk); addr = a; re = 1'b1; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic stat_is(input string tag, input logic [63:0] exp);
    logic [63:0] v;
    rd(STAT, v);
    chk(tag, v, exp);
    chk({tag, " irq"}, {63'd0, irq}, {63'd0, exp != 0});
  endtask

  task automatic t_reset;
    logic [63:0] v;
    rd(MASK, v); chk("R1 mask", v, 64'h5F80);
    stat_is("R1 status", 0);
  endtask

  task automatic t_masked_drop;
    wr(KLEN, 64'd20);
    stat_is("R2 masked drop", 0);
  endtask

  task automatic t_mask_rsvd;
    logic [63:0] v;
    wr(MASK, '1); rd(MASK, v); chk("R10 mask reserved", v, 64'h5F80);
    wr(MASK, 0); rd(MASK, v); chk("R10 mask clear", v, 0);
  endtask

  task automatic t_klen;
    wr(KLEN, 64'd16); wr(KLEN, 64'd24); wr(KLEN, 64'd32);
    stat_is("R3 legal lengths", 0);
    wr(KLEN, 64'd20);
    stat_is("R3 bad length", fb(54));
    repeat (3) @(negedge clk);
    stat_is("R8 sticky", fb(54));
    wr(STAT, fb(54));
    stat_is("R8 w1c", 0);
  endtask

  task automatic t_early;
    logic [63:0] v;
    busy = 1'b1; rd(STAT, v); rd(MASK, v); busy = 1'b0;
    stat_is("R4 status read busy", 0);
    busy = 1'b1; rd(IV0, v); busy = 1'b0;
    stat_is("R4 iv read busy", fb(52));
    wr(STAT, '1);
  endtask

  task automatic t_busyw;
    wr(KEY1, 64'h1234);
    stat_is("R5 idle write", 0);
    busy = 1'b1; wr(KEY1, 64'h1234); busy = 1'b0;
    stat_is("R5 busy write", fb(53));
    wr(STAT, '1);
  endtask

  task automatic t_mode;
    wr(MODE, 64'h00FF);
    stat_is("R6 legal mode", 0);
    wr(MODE, 64'h0100);
    stat_is("R6 reserved mode bit", fb(56));
    wr(STAT, '1);
  endtask

  task automatic t_inputs;
    size_ok = 1'b0; wr(DLEN, 64'd8); size_ok = 1'b1;
    stat_is("R7 data length", fb(55));
    wr(STAT, '1);
    @(negedge clk); core_fault = 1'b1;
    @(negedge clk); core_fault = 1'b0;
    chk("R9 irq next cycle", {63'd0, irq}, 64'd1);
    stat_is("R7 core fault", fb(51));
    wr(STAT, '1);
  endtask

  task automatic t_priority;
    @(negedge clk); icv_bad = 1'b1;
    @(negedge clk); icv_bad = 1'b0;
    @(negedge clk); addr = STAT; wdata = fb(49); we = 1'b1; icv_bad = 1'b1;
    @(negedge clk); we = 1'b0; icv_bad = 1'b0;
    stat_is("R8 set beats clear", fb(49));
    wr(MASK, fb(49));
    stat_is("R2 mask hides", 0);
    wr(MASK, 0);
    stat_is("R2 mask cleared bit", 0);
    wr(STAT, 64'hFFFF_0000_0000_0000);
    stat_is("R10 status reserved", 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masked_drop();
    t_mask_rsvd();
    t_klen();
    t_early();
    t_busyw();
    t_mode();
    t_inputs();
    t_priority();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule